// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers interrupt sources into several identical banks. Each bank takes 32 level-sensitive sources and latches them into sticky pending bits. A per-bank enable word decides which pending bits may reach that bank's request line to the processor. Software clears a pending bit by writing a one to it, and writing a zero leaves the bit alone.

Every bank decodes its own register window, and the windows repeat at a fixed byte stride. Each bank drives one request output. Next to each request output, the bank gives the index of its highest-numbered pending, enabled source. Interrupt handlers use that index directly, because only the most significant pending bit is taken as trustworthy.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0, every request output is 0, and register reads return 0.
- R2: A source input that is high at a clock edge sets its pending bit at that edge. The bit stays set after the source falls, until software clears it.
- R3: A register write to the pending word (bank offset 0x00) clears each bit written as 1. Bits written as 0 are left unchanged.
- R4: When a source is high in the same cycle that software clears its pending bit, the bit stays set.
- R5: The enable word (bank offset 0x08) is read/write and resets to 0. The gated view (bank offset 0x10) reads pending AND enable, and reads 0 when no enabled source is pending.
- R6: Request output i is the OR of bank i's gated view, registered once. It goes high on the clock edge after the edge that made the gated view non-zero.
- R7: Each bank's index output is the bit number of the highest set bit of its gated view. It is registered in step with the request.
- R8: Bank n's window starts at byte address n × 0x28, and there are 5 banks by default. Bank n drives request bit n and index field bits [5n+4:5n]. An access to one bank leaves every other bank unchanged.
- R9: The raw view (bank offset 0x18) reads the bank's source levels as sampled at the previous clock edge.
- R10: The blocked view (bank offset 0x20) reads pending AND NOT enable.
- R11: A read at an unused offset inside a window, or at an address past the last window, returns 0. A write to such an address changes nothing.
- R12: A read returns its data on the clock edge after the read strobe. That data reflects writes made on earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| srcIn | input | 160 | Source levels, bank n at bits [32n+31:32n] |
| irqReq | output | 5 | Per-bank request lines |
| topIdx | output | 25 | Per-bank highest pending enabled index, 5 bits each |

## Verification
A pending bit that is stuck or lost shows at the ports within two cycles. It appears on the request line and the index field the cycle after the gated view changes, and in a pending-word read one cycle after the strobe. A bad address decode shows up as a write that lands in a neighbouring bank, so the bench reads back banks it did not address and checks the request lines it did not expect to move. A bad priority encoder shows up in the index field once two enabled bits are pending together.

// File: rtl/bicu_pkg.sv
package bicu_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ENABLE,
    SEL_GATED,
    SEL_RAW,
    SEL_BLOCKED
  } regSel_e;

  typedef struct packed {
    logic    wrStrobe;
    logic    rdStrobe;
    regSel_e sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/bicu_ctrl.sv
module bicu_ctrl
  import bicu_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int ADDR_W      = 8,
  parameter int BANK_STRIDE = 40,
  parameter int BANK_W      = 3
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strb,
  output logic [BANK_W-1:0] bankSel
);
  localparam int OFF_PEND    = 0;
  localparam int OFF_ENABLE  = 8;
  localparam int OFF_GATED   = 16;
  localparam int OFF_RAW     = 24;
  localparam int OFF_BLOCKED = 32;

  always_comb begin
    int      offs;
    logic    hit;
    regSel_e sel;
    offs    = 0;
    hit     = 1'b0;
    bankSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(regAddr) >= b * BANK_STRIDE && int'(regAddr) < (b + 1) * BANK_STRIDE) begin
        hit     = 1'b1;
        bankSel = BANK_W'(b);
        offs    = int'(regAddr) - b * BANK_STRIDE;
      end
    end
    case (offs)
      OFF_PEND:    sel = SEL_PEND;
      OFF_ENABLE:  sel = SEL_ENABLE;
      OFF_GATED:   sel = SEL_GATED;
      OFF_RAW:     sel = SEL_RAW;
      OFF_BLOCKED: sel = SEL_BLOCKED;
      default:     sel = SEL_NONE;
    endcase
    if (!hit) sel = SEL_NONE;
    strb.sel      = sel;
    strb.wrStrobe = regWe && (sel == SEL_PEND || sel == SEL_ENABLE);
    strb.rdStrobe = regRe;
  end
endmodule

// File: rtl/bicu_datapath.sv
module bicu_datapath
  import bicu_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int SRC_W     = 32,
  parameter int IDX_W     = 5,
  parameter int BANK_W    = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strb,
  input  logic [BANK_W-1:0]            bankSel,
  input  logic [SRC_W-1:0]             regWdata,
  input  logic [NUM_BANKS*SRC_W-1:0]   srcIn,
  output logic [SRC_W-1:0]             regRdata,
  output logic [NUM_BANKS-1:0]         irqReq,
  output logic [NUM_BANKS*IDX_W-1:0]   topIdx,
  output logic [NUM_BANKS*SRC_W-1:0]   statusAll,
  output logic [NUM_BANKS*SRC_W-1:0]   enableAll
);
  function automatic logic [IDX_W-1:0] msbIdx(input logic [SRC_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < SRC_W; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [SRC_W-1:0] pendArr  [NUM_BANKS];
  logic [SRC_W-1:0] enArr    [NUM_BANKS];
  logic [SRC_W-1:0] rawArr   [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SRC_W-1:0] pend, en, raw, gated, clr;
    logic             req;
    logic [IDX_W-1:0] idx;
    logic             here;

    assign here  = (bankSel == BANK_W'(b));
    assign gated = pend & en;
    assign clr   = (strb.wrStrobe && strb.sel == SEL_PEND && here) ? regWdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend <= '0;
        en   <= '0;
        raw  <= '0;
        req  <= 1'b0;
        idx  <= '0;
      end else begin
        pend <= (pend & ~clr) | srcIn[b*SRC_W +: SRC_W];
        if (strb.wrStrobe && strb.sel == SEL_ENABLE && here) en <= regWdata;
        raw  <= srcIn[b*SRC_W +: SRC_W];
        req  <= |gated;
        idx  <= msbIdx(gated);
      end
    end

    assign pendArr[b]                 = pend;
    assign enArr[b]                   = en;
    assign rawArr[b]                  = raw;
    assign irqReq[b]                  = req;
    assign topIdx[b*IDX_W +: IDX_W]   = idx;
    assign statusAll[b*SRC_W +: SRC_W] = pend;
    assign enableAll[b*SRC_W +: SRC_W] = en;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (strb.rdStrobe) begin
      case (strb.sel)
        SEL_PEND:    regRdata <= pendArr[bankSel];
        SEL_ENABLE:  regRdata <= enArr[bankSel];
        SEL_GATED:   regRdata <= pendArr[bankSel] & enArr[bankSel];
        SEL_RAW:     regRdata <= rawArr[bankSel];
        SEL_BLOCKED: regRdata <= pendArr[bankSel] & ~enArr[bankSel];
        default:     regRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bicu_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int SRC_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int BANK_STRIDE = 40
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWe,
  input  logic                             regRe,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [SRC_W-1:0]                 regWdata,
  output logic [SRC_W-1:0]                 regRdata,
  input  logic [NUM_BANKS*SRC_W-1:0]       srcIn,
  output logic [NUM_BANKS-1:0]             irqReq,
  output logic [NUM_BANKS*$clog2(SRC_W)-1:0] topIdx
);
  localparam int IDX_W  = $clog2(SRC_W);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  ctrlStrobe_t                 strb;
  logic [BANK_W-1:0]           bankSel;
  logic [NUM_BANKS*SRC_W-1:0]  statusAll;
  logic [NUM_BANKS*SRC_W-1:0]  enableAll;

  bicu_ctrl #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_STRIDE(BANK_STRIDE), .BANK_W(BANK_W)
  ) u_ctrl (
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .strb(strb), .bankSel(bankSel)
  );

  bicu_datapath #(
    .NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W), .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bankSel(bankSel), .regWdata(regWdata),
    .srcIn(srcIn), .regRdata(regRdata), .irqReq(irqReq), .topIdx(topIdx),
    .statusAll(statusAll), .enableAll(enableAll)
  );
endmodule

// File: rtl/bicu_checker.sv
module bicu_checker #(
  parameter int NUM_BANKS = 5,
  parameter int SRC_W     = 32,
  parameter int IDX_W     = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       regWe,
  input logic [NUM_BANKS*SRC_W-1:0] srcIn,
  input logic [NUM_BANKS-1:0]       irqReq,
  input logic [NUM_BANKS*IDX_W-1:0] topIdx,
  input logic [NUM_BANKS*SRC_W-1:0] statusAll,
  input logic [NUM_BANKS*SRC_W-1:0] enableAll
);
  // R2 and R4: a high source is pending on the next edge, whatever was written
  a_r2_source_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusAll & $past(srcIn)) == $past(srcIn)));

  // R3: without a write no pending bit is lost
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ((statusAll & $past(statusAll)) == $past(statusAll)));

  // R5: enable word moves only on a write
  a_r5_enable_stable: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(enableAll));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R6: nothing pending and enabled means no request one edge later
    a_r6_no_req_idle: assert property (@(posedge clk) disable iff (!rstN)
      ((statusAll[b*SRC_W +: SRC_W] & enableAll[b*SRC_W +: SRC_W]) == '0) |=> !irqReq[b]);

    // R7: the index names the top bit of the gated view one edge earlier
    a_r7_index_is_top: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[b] |-> (($past(statusAll[b*SRC_W +: SRC_W] & enableAll[b*SRC_W +: SRC_W])
                      >> topIdx[b*IDX_W +: IDX_W]) == SRC_W'(1)));
  end
endmodule

bind banked_irq_ctrl bicu_checker #(
  .NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .srcIn(srcIn), .irqReq(irqReq),
  .topIdx(topIdx), .statusAll(statusAll), .enableAll(enableAll)
);

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  localparam int NB = 5;
  localparam int SW = 32;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWe = 1'b0;
  logic            regRe = 1'b0;
  logic [7:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NB*SW-1:0] srcIn = '0;
  logic [NB-1:0]   irqReq;
  logic [NB*IW-1:0] topIdx;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  banked_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcIn(srcIn), .irqReq(irqReq), .topIdx(topIdx)
  );

  function automatic logic [7:0] addrOf(input int bank, input int off);
    return 8'(bank * 40 + off);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regRe = 1'b1; regAddr = a;
    @(negedge clk);
    regRe = 1'b0;
    d = regRdata;
  endtask

  task automatic pulseSrc(input int bank, input int bit_n);
    srcIn[bank*SW + bit_n] = 1'b1;
    @(negedge clk);
    srcIn[bank*SW + bit_n] = 1'b0;
  endtask

  task automatic tReset;
    logic [31:0] d;
    check("R1 irqReq", 32'(irqReq), 32'h0);
    rdReg(addrOf(0, 0), d);  check("R1 pending bank0", d, 32'h0);
    rdReg(addrOf(4, 8), d);  check("R1 enable bank4", d, 32'h0);
    check("R1 topIdx", 32'(topIdx), 32'h0);
  endtask

  task automatic tSticky;
    logic [31:0] d;
    pulseSrc(0, 5);
    rdReg(addrOf(0, 0), d);  check("R2 pending set", d, 32'h20);
    @(negedge clk);
    rdReg(addrOf(0, 0), d);  check("R2 pending sticky", d, 32'h20);
    rdReg(addrOf(0, 24), d); check("R9 raw low", d, 32'h0);
    srcIn[3] = 1'b1;
    @(negedge clk);
    rdReg(addrOf(0, 24), d); check("R9 raw high", d, 32'h8);
    srcIn[3] = 1'b0;
    @(negedge clk);
  endtask

  task automatic tClear;
    logic [31:0] d;
    wrReg(addrOf(0, 0), 32'h20);
    rdReg(addrOf(0, 0), d);  check("R3 clear one bit", d, 32'h8);
    wrReg(addrOf(0, 0), 32'h0);
    rdReg(addrOf(0, 0), d);  check("R3 zero write keeps", d, 32'h8);
    wrReg(addrOf(0, 0), 32'h8);
    rdReg(addrOf(0, 0), d);  check("R12 read after write", d, 32'h0);
  endtask

  task automatic tSetWins;
    logic [31:0] d;
    srcIn[7] = 1'b1;
    @(negedge clk);
    wrReg(addrOf(0, 0), 32'h80);
    rdReg(addrOf(0, 0), d);  check("R4 set wins", d, 32'h80);
    srcIn[7] = 1'b0;
    @(negedge clk);
    wrReg(addrOf(0, 0), 32'h80);
    rdReg(addrOf(0, 0), d);  check("R4 cleared after release", d, 32'h0);
  endtask

  task automatic tGate;
    logic [31:0] d;
    pulseSrc(2, 4);
    pulseSrc(2, 20);
    rdReg(addrOf(2, 16), d); check("R5 gated zero", d, 32'h0);
    check("R6 no request while disabled", 32'(irqReq), 32'h0);
    rdReg(addrOf(2, 32), d); check("R10 blocked view", d, 32'h0010_0010);
    wrReg(addrOf(2, 8), 32'h10);
    check("R6 not yet", 32'(irqReq), 32'h0);
    @(negedge clk);
    check("R6 request bank2", 32'(irqReq), 32'h4);
    check("R7 index low", 32'(topIdx[2*IW +: IW]), 32'd4);
    rdReg(addrOf(2, 16), d); check("R5 gated view", d, 32'h10);
    wrReg(addrOf(2, 8), 32'hFFFF_FFFF);
    @(negedge clk);
    check("R7 index top", 32'(topIdx[2*IW +: IW]), 32'd20);
    check("R8 only bank2 requests", 32'(irqReq), 32'h4);
    rdReg(addrOf(2, 8), d);  check("R5 enable readback", d, 32'hFFFF_FFFF);
    rdReg(addrOf(1, 8), d);  check("R8 bank1 untouched", d, 32'h0);
    rdReg(addrOf(2, 32), d); check("R10 blocked empty", d, 32'h0);
    wrReg(addrOf(2, 0), 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 request drops", 32'(irqReq), 32'h0);
  endtask

  task automatic tTopBank;
    logic [31:0] d;
    wrReg(addrOf(4, 8), 32'h8000_0000);
    pulseSrc(4, 31);
    @(negedge clk);
    check("R8 request bank4", 32'(irqReq), 32'h10);
    check("R7 index 31", 32'(topIdx[4*IW +: IW]), 32'd31);
    rdReg(addrOf(4, 16), d); check("R8 bank4 gated", d, 32'h8000_0000);
  endtask

  task automatic tUnmapped;
    logic [31:0] d;
    pulseSrc(0, 1);
    wrReg(addrOf(0, 4), 32'hFFFF_FFFF);
    wrReg(8'hC8, 32'hFFFF_FFFF);
    rdReg(addrOf(0, 8), d);  check("R11 enable unchanged", d, 32'h0);
    rdReg(addrOf(0, 0), d);  check("R11 pending unchanged", d, 32'h2);
    rdReg(addrOf(0, 4), d);  check("R11 hole reads zero", d, 32'h0);
    rdReg(8'hC8, d);         check("R11 past end reads zero", d, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSticky();
    tClear();
    tSetWins();
    tGate();
    tTopBank();
    tUnmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule